// File: doc/BRIEF.md
# Link Bring-Up Speed Sequencer

This controller brings a serial link up in two steps so that link partners such as switches, which can go undetected when training begins at a higher rate, are still found. After a start pulse it limits the link to first-generation speed and only then turns on training. It waits for the link to report up with training finished. If the configured maximum generation allows it, the controller then lifts the cap to second generation, issues a one-cycle directed speed-change request, waits for the change to complete, and checks that the link has come back up.

The negotiated speed is read from the link core and reported with a one-cycle done pulse. The controller polls once per clock cycle, and every wait has a parameterised limit. If any wait runs out, the controller recovers the receiver before it reports failure. Over a simple request/acknowledge PHY register port it sets two override bits in the receiver override register by read-modify-write, holds them for a programmable number of cycles, and then clears them by a second read-modify-write.

Top module: `lnk_speed_seq`

## Requirements
- R1: While the controller is idle, start_i moves speed_cap_o to 1 and drops train_en_o. train_en_o rises one cycle later, with the cap already at 1. A start_i that arrives while a sequence is running is ignored. After reset, speed_cap_o is 1 and train_en_o, spd_chg_req_o, phy_req_o and done_o are 0.
- R2: The link counts as up only in a cycle where link_up_i is 1 and in_training_i is 0. Each link wait polls once per cycle for at most LINK_POLLS cycles and fails if none of them sees the link up.
- R3: max_gen_i is sampled at start. If it is below 2, success at the speed the link core reports follows the first link-up directly, speed_cap_o stays at 1 and no speed-change request is made.
- R4: If max_gen_i is 2 or more, speed_cap_o becomes 2 in the cycle after the first link-up is seen. In the next cycle spd_chg_req_o pulses for exactly one cycle, while the cap is already 2.
- R5: After the request, spd_chg_busy_i is polled once per cycle for at most SPD_POLLS cycles, starting in the cycle after the pulse. The change is complete in the first polled cycle where the input is 0. If no polled cycle sees it at 0, the sequence fails.
- R6: After the speed change completes, a second link wait with the R2 rule and limit must succeed before success is reported. Otherwise the sequence fails.
- R7: done_o is a one-cycle pulse, exactly one per accepted start. On success fail_o is 0 and speed_o equals cur_speed_i as sampled in the final successful link poll.
- R8: On failure the controller reads PHY register 0x1005 and writes it back with bits 5 and 3 set. It waits HOLD_CYCLES cycles, reads the register again and writes it back with bits 5 and 3 cleared. It then pulses done_o with fail_o = 1 and speed_o = 0.
- R9: A PHY access holds phy_req_o, with phy_we_o stable, until phy_ack_i is seen; phy_we_o is 1 for writes. phy_addr_o is 0x1005 during every access. A successful sequence makes no PHY access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a bring-up sequence (accepted when idle) |
| max_gen_i | input | 4 | Highest generation allowed |
| link_up_i | input | 1 | Link core reports link up |
| in_training_i | input | 1 | Link core reports training in progress |
| spd_chg_busy_i | input | 1 | Directed speed change still pending |
| cur_speed_i | input | 4 | Current negotiated speed from the link core |
| phy_ack_i | input | 1 | PHY register access acknowledge (one cycle) |
| phy_rdata_i | input | 16 | PHY register read data, valid with ack |
| speed_cap_o | output | 4 | Maximum link speed cap to the link core |
| train_en_o | output | 1 | Link training enable |
| spd_chg_req_o | output | 1 | Directed speed-change request pulse |
| phy_req_o | output | 1 | PHY register access request |
| phy_we_o | output | 1 | PHY access is a write |
| phy_addr_o | output | 16 | PHY register address |
| phy_wdata_o | output | 16 | PHY register write data |
| done_o | output | 1 | Sequence finished (one-cycle pulse) |
| fail_o | output | 1 | Sequence failed, valid with done_o |
| speed_o | output | 4 | Reported speed, valid with done_o |

## Verification
Several properties are checked by assertions in every cycle: the cap is at 1 whenever training turns on, the cap rises to 2 only right after a qualified link-up, the speed-change request is a single cycle under a cap of 2, done is a pulse that carries speed 0 on failure, and PHY requests stay stable at the fixed address until acknowledged. Other behaviour can only be shown by the bench sweeps. These cover the exact poll-limit boundaries of each wait, including in-training masking and a link that drops during the speed change. They also cover the values written back in the override read-modify-writes, the hold interval between them, the speed sampled from the link core, and a start that is ignored while a sequence runs.

// File: rtl/lnk_seq_pkg.sv
package lnk_seq_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_ARM, S_W1, S_REQ, S_WSPD, S_W2, S_RGO, S_RWAIT, S_DONE
  } seq_state_e;

  typedef enum logic [2:0] {
    RX_IDLE, RX_RD1, RX_WR1, RX_HOLD, RX_RD2, RX_WR2, RX_FIN
  } rx_state_e;

  localparam logic [3:0]  SPD_GEN1     = 4'd1;
  localparam logic [3:0]  SPD_GEN2     = 4'd2;
  localparam logic [15:0] RX_OVRD_ADDR = 16'h1005;
  localparam logic [15:0] RX_OVRD_MASK = 16'h0028; // bits 5 and 3
endpackage

// File: rtl/lnk_poll_ctr.sv
module lnk_poll_ctr #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic [CW-1:0] limit_i,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (en_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == limit_i - 1'b1);
endmodule

// File: rtl/lnk_rx_rst.sv
module lnk_rx_rst
  import lnk_seq_pkg::*;
#(
  parameter int HOLD_CYCLES = 500000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        go_i,
  input  logic        phy_ack_i,
  input  logic [15:0] phy_rdata_i,
  output logic        phy_req_o,
  output logic        phy_we_o,
  output logic [15:0] phy_addr_o,
  output logic [15:0] phy_wdata_o,
  output logic        done_o
);
  localparam int HW = $clog2(HOLD_CYCLES + 1);

  rx_state_e   st_q;
  logic [15:0] wdata_q;
  logic        hold_last;

  lnk_poll_ctr #(.CW(HW)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (st_q != RX_HOLD),
    .en_i    (st_q == RX_HOLD),
    .limit_i (HW'(HOLD_CYCLES)),
    .last_o  (hold_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= RX_IDLE;
      wdata_q <= '0;
    end else begin
      case (st_q)
        RX_IDLE: if (go_i) st_q <= RX_RD1;
        RX_RD1: if (phy_ack_i) begin
          wdata_q <= phy_rdata_i | RX_OVRD_MASK;
          st_q    <= RX_WR1;
        end
        RX_WR1:  if (phy_ack_i) st_q <= RX_HOLD;
        RX_HOLD: if (hold_last) st_q <= RX_RD2;
        RX_RD2: if (phy_ack_i) begin
          wdata_q <= phy_rdata_i & ~RX_OVRD_MASK;
          st_q    <= RX_WR2;
        end
        RX_WR2:  if (phy_ack_i) st_q <= RX_FIN;
        RX_FIN:  st_q <= RX_IDLE;
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  assign phy_req_o   = (st_q == RX_RD1) || (st_q == RX_WR1) ||
                       (st_q == RX_RD2) || (st_q == RX_WR2);
  assign phy_we_o    = (st_q == RX_WR1) || (st_q == RX_WR2);
  assign phy_addr_o  = RX_OVRD_ADDR;
  assign phy_wdata_o = wdata_q;
  assign done_o      = (st_q == RX_FIN);
endmodule

// File: rtl/lnk_speed_seq.sv
module lnk_speed_seq
  import lnk_seq_pkg::*;
#(
  parameter int LINK_POLLS  = 100000,
  parameter int SPD_POLLS   = 200,
  parameter int HOLD_CYCLES = 500000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [3:0]  max_gen_i,
  input  logic        link_up_i,
  input  logic        in_training_i,
  input  logic        spd_chg_busy_i,
  input  logic [3:0]  cur_speed_i,
  input  logic        phy_ack_i,
  input  logic [15:0] phy_rdata_i,
  output logic [3:0]  speed_cap_o,
  output logic        train_en_o,
  output logic        spd_chg_req_o,
  output logic        phy_req_o,
  output logic        phy_we_o,
  output logic [15:0] phy_addr_o,
  output logic [15:0] phy_wdata_o,
  output logic        done_o,
  output logic        fail_o,
  output logic [3:0]  speed_o
);
  localparam int POLL_MAX = (LINK_POLLS > SPD_POLLS) ? LINK_POLLS : SPD_POLLS;
  localparam int CW       = $clog2(POLL_MAX + 1);

  seq_state_e    st_q, st_n;
  logic          gen2_q;
  logic          link_ok, poll_last, poll_en, rx_done;
  logic [CW-1:0] poll_lim;

  assign link_ok  = link_up_i && !in_training_i;
  assign poll_en  = (st_q == S_W1) || (st_q == S_WSPD) || (st_q == S_W2);
  assign poll_lim = (st_q == S_WSPD) ? CW'(SPD_POLLS) : CW'(LINK_POLLS);

  lnk_poll_ctr #(.CW(CW)) u_poll (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (st_q != st_n),
    .en_i    (poll_en),
    .limit_i (poll_lim),
    .last_o  (poll_last)
  );

  always_comb begin
    st_n = st_q;
    case (st_q)
      S_IDLE:  if (start_i) st_n = S_ARM;
      S_ARM:   st_n = S_W1;
      S_W1: begin
        if (link_ok)        st_n = gen2_q ? S_REQ : S_DONE;
        else if (poll_last) st_n = S_RGO;
      end
      S_REQ:   st_n = S_WSPD;
      S_WSPD: begin
        if (!spd_chg_busy_i) st_n = S_W2;
        else if (poll_last)  st_n = S_RGO;
      end
      S_W2: begin
        if (link_ok)        st_n = S_DONE;
        else if (poll_last) st_n = S_RGO;
      end
      S_RGO:   st_n = S_RWAIT;
      S_RWAIT: if (rx_done) st_n = S_DONE;
      S_DONE:  st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= S_IDLE;
      gen2_q      <= 1'b0;
      speed_cap_o <= SPD_GEN1;
      train_en_o  <= 1'b0;
      fail_o      <= 1'b0;
      speed_o     <= '0;
    end else begin
      st_q <= st_n;
      case (st_q)
        S_IDLE: if (start_i) begin
          speed_cap_o <= SPD_GEN1;
          train_en_o  <= 1'b0;
          gen2_q      <= (max_gen_i >= SPD_GEN2);
          fail_o      <= 1'b0;
          speed_o     <= '0;
        end
        S_ARM: train_en_o <= 1'b1;
        S_W1: if (link_ok) begin
          if (gen2_q) speed_cap_o <= SPD_GEN2;
          else        speed_o     <= cur_speed_i;
        end
        S_W2: if (link_ok) speed_o <= cur_speed_i;
        S_RGO: begin
          fail_o  <= 1'b1;
          speed_o <= '0;
        end
        default: ;
      endcase
    end
  end

  assign spd_chg_req_o = (st_q == S_REQ);
  assign done_o        = (st_q == S_DONE);

  lnk_rx_rst #(.HOLD_CYCLES(HOLD_CYCLES)) u_rx_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (st_q == S_RGO),
    .phy_ack_i   (phy_ack_i),
    .phy_rdata_i (phy_rdata_i),
    .phy_req_o   (phy_req_o),
    .phy_we_o    (phy_we_o),
    .phy_addr_o  (phy_addr_o),
    .phy_wdata_o (phy_wdata_o),
    .done_o      (rx_done)
  );
endmodule

// File: rtl/lnk_speed_seq_chk.sv
module lnk_speed_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic [3:0]  max_gen_i,
  input logic        link_up_i,
  input logic        in_training_i,
  input logic        spd_chg_busy_i,
  input logic [3:0]  cur_speed_i,
  input logic        phy_ack_i,
  input logic [15:0] phy_rdata_i,
  input logic [3:0]  speed_cap_o,
  input logic        train_en_o,
  input logic        spd_chg_req_o,
  input logic        phy_req_o,
  input logic        phy_we_o,
  input logic [15:0] phy_addr_o,
  input logic [15:0] phy_wdata_o,
  input logic        done_o,
  input logic        fail_o,
  input logic [3:0]  speed_o
);
  a_r1_cap_before_train: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(train_en_o) |-> speed_cap_o == 4'd1);

  a_r4_raise_after_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (speed_cap_o == 4'd2 && $past(speed_cap_o) != 4'd2) |->
      $past(link_up_i && !in_training_i));

  a_r4_req_under_cap2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spd_chg_req_o |-> speed_cap_o == 4'd2);

  a_r4_req_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spd_chg_req_o |=> !spd_chg_req_o);

  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_fail_speed_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fail_o) |-> speed_o == 4'd0);

  a_r9_phy_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_req_o |-> phy_addr_o == 16'h1005);

  a_r9_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phy_req_o && !phy_ack_i) |=> (phy_req_o && $stable(phy_we_o)));
endmodule

bind lnk_speed_seq lnk_speed_seq_chk u_chk (.*);

// File: tb/tb_lnk_speed_seq.sv
`timescale 1ns/1ps
module tb_lnk_speed_seq;
  localparam int LP = 6;
  localparam int SP = 5;
  localparam int HC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        start, link_up, in_trn, busy, phy_ack;
  logic [3:0]  max_gen, cur_spd, cap, speed;
  logic [15:0] phy_rdata, phy_addr, phy_wdata;
  logic        train_en, spd_req, phy_req, phy_we, done, fail;

  lnk_speed_seq #(.LINK_POLLS(LP), .SPD_POLLS(SP), .HOLD_CYCLES(HC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .max_gen_i(max_gen),
    .link_up_i(link_up), .in_training_i(in_trn), .spd_chg_busy_i(busy),
    .cur_speed_i(cur_spd), .phy_ack_i(phy_ack), .phy_rdata_i(phy_rdata),
    .speed_cap_o(cap), .train_en_o(train_en), .spd_chg_req_o(spd_req),
    .phy_req_o(phy_req), .phy_we_o(phy_we), .phy_addr_o(phy_addr),
    .phy_wdata_o(phy_wdata), .done_o(done), .fail_o(fail), .speed_o(speed)
  );

  // link core and PHY model
  int md, mt, ms, mr;
  logic mdl_clr;
  logic [15:0] phy_init, phy_reg, w1, w2;
  int tcnt, bcnt, dcnt, n_rd, n_wr, n_req, cyc, t_wr1, t_rd2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt <= 0; bcnt <= 0; dcnt <= 0; n_rd <= 0; n_wr <= 0; n_req <= 0;
      cyc <= 0; t_wr1 <= 0; t_rd2 <= 0; w1 <= '0; w2 <= '0;
      phy_reg <= '0; phy_ack <= 1'b0;
    end else begin
      cyc <= cyc + 1;
      phy_ack <= phy_req && !phy_ack;
      if (mdl_clr) begin
        tcnt <= 0; bcnt <= 0; dcnt <= 0; n_rd <= 0; n_wr <= 0; n_req <= 0;
        t_wr1 <= 0; t_rd2 <= 0; w1 <= '0; w2 <= '0; phy_reg <= phy_init;
      end else begin
        tcnt <= train_en ? tcnt + 1 : 0;
        if (spd_req) begin
          bcnt <= ms; dcnt <= mr; n_req <= n_req + 1;
        end else begin
          if (bcnt > 0) bcnt <= bcnt - 1;
          if (dcnt > 0) dcnt <= dcnt - 1;
        end
        if (phy_req && phy_ack) begin
          if (phy_we) begin
            phy_reg <= phy_wdata;
            n_wr <= n_wr + 1;
            if (n_wr == 0) begin w1 <= phy_wdata; t_wr1 <= cyc; end
            else w2 <= phy_wdata;
          end else begin
            n_rd <= n_rd + 1;
            if (n_rd == 1) t_rd2 <= cyc;
          end
        end
      end
    end
  end

  always_comb begin
    link_up   = train_en && (tcnt >= md) && (dcnt == 0);
    in_trn    = train_en && (tcnt < md + mt);
    busy      = (bcnt != 0);
    cur_spd   = (n_req > 0) ? 4'd2 : 4'd1;
    phy_rdata = phy_reg;
  end

  int checks = 0;
  int fails  = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run(int g, int d, int t, int s, int r, logic [15:0] pi);
    int nd = 0;
    int post = 0;
    bit seen = 0;
    int f = 0, sp = 0, cp = 0;
    bit gen2, ok1, efail;
    int ecap, ereq, espd;
    @(negedge clk);
    md = d; mt = t; ms = s; mr = r; phy_init = pi; max_gen = 4'(g);
    start = 1'b1; mdl_clr = 1'b1;
    @(negedge clk);
    mdl_clr = 1'b0;           // start held one more cycle: R1 ignored while busy
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      if (done) begin
        nd++;
        if (!seen) begin f = int'(fail); sp = int'(speed); cp = int'(cap); end
        seen = 1;
      end
      if (seen) begin
        post++;
        if (post > 5) break;
      end
    end
    gen2 = (g >= 2);
    ok1  = (d + t <= LP - 1);
    if (!ok1) begin
      efail = 1; ecap = 1; ereq = 0;
    end else if (!gen2) begin
      efail = 0; ecap = 1; ereq = 0;
    end else begin
      ecap = 2; ereq = 1;
      efail = (s <= SP - 1) ? !(r <= s + LP) : 1'b1;
    end
    espd = efail ? 0 : (gen2 ? 2 : 1);
    chk("R7 done pulse count", nd, 1);
    chk("R2/R5/R6 fail flag", f, int'(efail));
    chk("R7 reported speed", sp, espd);
    chk("R1/R4 speed cap", cp, ecap);
    chk("R3/R4 speed-change requests", n_req, ereq);
    chk("R9 PHY reads", n_rd, efail ? 2 : 0);
    chk("R9 PHY writes", n_wr, efail ? 2 : 0);
    if (efail) begin
      chk("R8 set write value", int'(w1), int'(pi | 16'h0028));
      chk("R8 clear write value", int'(w2), int'((pi | 16'h0028) & ~16'h0028));
      chk("R8 hold interval", int'(t_rd2 - t_wr1 >= HC + 1), 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    start = 1'b0; mdl_clr = 1'b0; max_gen = 4'd1;
    md = 0; mt = 0; ms = 0; mr = 0; phy_init = 16'h1247;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset cap", int'(cap), 1);
    chk("R1 reset train_en", int'(train_en), 0);
    chk("R1 reset request", int'(spd_req), 0);
    chk("R1 reset done", int'(done), 0);
    chk("R9 reset phy_req", int'(phy_req), 0);

    // R2/R3: Gen1-only sweeps over link-up delay and in-training masking
    for (int g = 0; g < 2; g++)
      for (int d = 0; d <= LP; d++)
        for (int t = 0; t <= 2; t += 2)
          run(g, d, t, 0, 0, (d % 2 == 1) ? 16'hFFFF : 16'h1247);

    // R4/R5/R6: Gen2 sweeps over speed-change time and retrain delay
    for (int d = 0; d <= LP; d++)
      for (int t = 0; t <= 2; t += 2)
        for (int s = 0; s <= SP; s++) begin
          run(2, d, t, s, 0, 16'h1247);
          run(2, d, t, s, s + LP, 16'hFFFF);
          run(2, d, t, s, s + LP + 1, 16'h5A5A);
        end

    // max_gen above 2 treated as Gen2 allowed
    for (int s = 0; s <= SP; s++) run(3, 1, 0, s, 1, 16'h0000);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule